// File: doc/BRIEF.md
# Three-Phase Bridge Protection Supervisor

This block sits between the filtered command inputs of a three-phase half-bridge gate driver and its output stages, and decides, every clock cycle, which of the six gate outputs may be driven. It watches a digital over-current trip flag, a logic-supply undervoltage flag, one floating-supply undervoltage flag per phase and one negative-offset-transient flag per phase. From these it produces a high-side enable and a low-side enable per phase, plus an active-low fault indication with a separate pull-down enable that models an open-drain pin.

An over-current trip must persist for a blanking interval before it counts. Once it counts, it shuts the whole bridge down and latches. The latch is released only after the trip flag has dropped and all three low-side commands have rested at their inactive level for an unbroken clear interval. A logic-supply undervoltage also shuts the bridge down and raises the fault, but it is not remembered. Per-phase floating-supply undervoltage and offset transients affect only the high side of their own phase. A high side that has been blocked by undervoltage, or by reset, comes back only on a fresh turn-on edge of its command. All commands are active-low.

Top module: `bridge_guard`

## Requirements
- R1: When `trip` is sampled high on BLANK_CYC consecutive rising edges, all bits of `hs_en` and `ls_en` are 0 and `flt_drv` is 1 from the cycle after the last of those edges. A trip high on fewer consecutive edges changes no output.
- R2: After a trip fault has latched, it stays active (`flt_drv` = 1, all enables 0) even when `trip` is low, for as long as any bit of `lin_n` is 0.
- R3: The trip fault clears after CLEAR_CYC consecutive rising edges that each sample `trip` = 0 and `lin_n` = 3'b111. It is released in the cycle after the last of those edges. A cycle with `trip` high, or with any `lin_n` bit low, restarts the count.
- R4: While `vcc_uv` is 1, all enables are 0 and `flt_drv` is 1 in the same cycle. The condition is not latched: when `vcc_uv` returns to 0 with no trip fault, the outputs recover in that same cycle.
- R5: `vbs_uv[i]` = 1 forces `hs_en[i]` to 0 in the same cycle. It leaves `ls_en`, the other phases' `hs_en` and `flt_drv` unchanged.
- R6: After `vbs_uv[i]` returns to 0, `hs_en[i]` stays 0 until a turn-on edge is seen: `hin_n[i]` sampled 1 on one rising edge and 0 on the next, with `vbs_uv[i]` = 0. `hs_en[i]` becomes 1 in the cycle after that edge. An edge taken while `vbs_uv[i]` = 1 is ignored.
- R7: `neg_tr[i]` = 1 forces `hs_en[i]` to 0 while it is high, and for HOLD_CYC further cycles after the last rising edge that sampled it high. Other phases are unaffected.
- R8: While `rst` is 1, every enable and `flt_drv` are 0. After reset, `ls_en` = 3'b111, no fault is active, and every high side waits for a turn-on edge as in R6. A command already low when reset ends does not count as an edge.
- R9: `flt_n` is always the inverse of `flt_drv`. `flt_drv` = 1 (pin pulled low) exactly while a trip fault is latched or `vcc_uv` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hin_n | input | PHASES | Filtered high-side commands, active low |
| lin_n | input | PHASES | Filtered low-side commands, active low |
| trip | input | 1 | Over-current trip flag, active high |
| vcc_uv | input | 1 | Logic-supply undervoltage flag |
| vbs_uv | input | PHASES | Per-phase floating-supply undervoltage flags |
| neg_tr | input | PHASES | Per-phase qualified negative offset transient flags |
| hs_en | output | PHASES | Per-phase high-side output enables |
| ls_en | output | PHASES | Per-phase low-side output enables |
| flt_drv | output | 1 | Fault pin pull-down enable (0 = high impedance) |
| flt_n | output | 1 | Fault level, active low |

## Verification
The hardest situation to reach is a fault-clear run that is broken partway through. This needs a latched trip, a partial count of idle low-side cycles, and then a single cycle in which one low-side command goes active. The stimulus latches the fault and first holds `trip` high with the commands idle, to show that a live trip blocks the count. It then releases the trip with the commands still active, runs a short idle stretch, breaks it with one active command, and only then gives a full-length idle run. The release cycle is checked on both sides. The high-side rearm rule is exercised the same way: a turn-on edge is given during undervoltage and is expected to be ignored.

// File: rtl/bridge_guard_pkg.sv
package bridge_guard_pkg;

    // Per-phase inputs that affect only the high side of that phase
    typedef struct packed {
        logic hin_n;    // active-low high-side command
        logic vbs_uv;   // floating supply below threshold
        logic neg_tr;   // qualified negative offset transient
    } phase_in_t;

    // Sources that pull the fault pin low
    typedef struct packed {
        logic latched;     // qualified over-current, remembered
        logic supply_low;  // logic supply undervoltage, not remembered
    } fault_src_t;

    function automatic logic fault_active(input fault_src_t s);
        return s.latched | s.supply_low;
    endfunction

    // Turn-on edge of an active-low command: previous high, current low
    function automatic logic turn_on_edge(input logic prev_lvl, input logic cur_lvl);
        return prev_lvl & ~cur_lvl;
    endfunction

endpackage

// File: rtl/trip_blanker.sv
module trip_blanker #(
    parameter int BLANK_CYC = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic trip,
    output logic qualified
);
    localparam int CW = $clog2(BLANK_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(BLANK_CYC - 1);

    logic [CW-1:0] run_q;

    // Count consecutive high samples, saturating at the last step
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (!trip) begin
            run_q <= '0;
        end else if (run_q != LAST) begin
            run_q <= run_q + 1'b1;
        end
    end

    // High on the sample that completes the blanking run and beyond
    assign qualified = trip & (run_q == LAST);

endmodule

// File: rtl/fault_keeper.sv
module fault_keeper #(
    parameter int CLEAR_CYC = 2125
) (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic trip,
    input  logic low_idle,
    output logic latched
);
    localparam int CW = $clog2(CLEAR_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(CLEAR_CYC - 1);

    logic [CW-1:0] quiet_q;
    logic          latch_q;
    logic          quiet_ok;

    assign quiet_ok = latch_q & ~trip & low_idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= 1'b0;
            quiet_q <= '0;
        end else if (set_req) begin
            latch_q <= 1'b1;
            quiet_q <= '0;
        end else if (!quiet_ok) begin
            quiet_q <= '0;
        end else if (quiet_q == LAST) begin
            latch_q <= 1'b0;
            quiet_q <= '0;
        end else begin
            quiet_q <= quiet_q + 1'b1;
        end
    end

    assign latched = latch_q;

endmodule

// File: rtl/hs_phase_gate.sv
module hs_phase_gate
    import bridge_guard_pkg::*;
#(
    parameter int HOLD_CYC = 1125
) (
    input  logic      clk,
    input  logic      rst,
    input  phase_in_t pin,
    output logic      permit
);
    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam logic [HW-1:0] HOLD_LOAD = HW'(HOLD_CYC);

    logic          prev_q;
    logic          wait_q;
    logic [HW-1:0] hold_q;
    logic          edge_seen;
    logic          holding;

    assign edge_seen = turn_on_edge(prev_q, pin.hin_n);

    // Command history; reset low so a command already active is not an edge
    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= pin.hin_n;
    end

    // Rearm: set by reset or undervoltage, cleared by a fresh turn-on edge
    always_ff @(posedge clk) begin
        if (rst)             wait_q <= 1'b1;
        else if (pin.vbs_uv) wait_q <= 1'b1;
        else if (edge_seen)  wait_q <= 1'b0;
    end

    // Transient hold timer, reloaded while the flag is present
    always_ff @(posedge clk) begin
        if (rst)                 hold_q <= '0;
        else if (pin.neg_tr)     hold_q <= HOLD_LOAD;
        else if (hold_q != '0)   hold_q <= hold_q - 1'b1;
    end

    assign holding = pin.neg_tr | (hold_q != '0);
    assign permit  = ~wait_q & ~pin.vbs_uv & ~holding;

endmodule

// File: rtl/bridge_guard.sv
module bridge_guard
    import bridge_guard_pkg::*;
#(
    parameter int PHASES    = 3,
    parameter int BLANK_CYC = 100,
    parameter int CLEAR_CYC = 2125,
    parameter int HOLD_CYC  = 1125
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PHASES-1:0] hin_n,
    input  logic [PHASES-1:0] lin_n,
    input  logic              trip,
    input  logic              vcc_uv,
    input  logic [PHASES-1:0] vbs_uv,
    input  logic [PHASES-1:0] neg_tr,
    output logic [PHASES-1:0] hs_en,
    output logic [PHASES-1:0] ls_en,
    output logic              flt_drv,
    output logic              flt_n
);
    logic              trip_ok;
    logic              trip_latched;
    logic              low_idle;
    logic [PHASES-1:0] hs_permit;
    fault_src_t        src;
    logic              bridge_off;

    assign low_idle = &lin_n;

    trip_blanker #(.BLANK_CYC(BLANK_CYC)) u_blank (
        .clk       (clk),
        .rst       (rst),
        .trip      (trip),
        .qualified (trip_ok)
    );

    fault_keeper #(.CLEAR_CYC(CLEAR_CYC)) u_keep (
        .clk      (clk),
        .rst      (rst),
        .set_req  (trip_ok),
        .trip     (trip),
        .low_idle (low_idle),
        .latched  (trip_latched)
    );

    for (genvar p = 0; p < PHASES; p++) begin : g_phase
        phase_in_t pin;
        assign pin.hin_n  = hin_n[p];
        assign pin.vbs_uv = vbs_uv[p];
        assign pin.neg_tr = neg_tr[p];

        hs_phase_gate #(.HOLD_CYC(HOLD_CYC)) u_gate (
            .clk    (clk),
            .rst    (rst),
            .pin    (pin),
            .permit (hs_permit[p])
        );
    end

    assign src.latched    = trip_latched;
    assign src.supply_low = vcc_uv;
    assign bridge_off     = fault_active(src);

    always_comb begin
        if (rst) begin
            hs_en   = '0;
            ls_en   = '0;
            flt_drv = 1'b0;
        end else begin
            ls_en   = bridge_off ? '0 : '1;
            hs_en   = bridge_off ? '0 : hs_permit;
            flt_drv = bridge_off;
        end
    end

    assign flt_n = ~flt_drv;

endmodule

// File: rtl/bridge_guard_chk.sv
module bridge_guard_chk #(
    parameter int PHASES    = 3,
    parameter int BLANK_CYC = 100
) (
    input logic              clk,
    input logic              rst,
    input logic [PHASES-1:0] lin_n,
    input logic              trip,
    input logic              vcc_uv,
    input logic [PHASES-1:0] vbs_uv,
    input logic [PHASES-1:0] neg_tr,
    input logic [PHASES-1:0] hs_en,
    input logic [PHASES-1:0] ls_en,
    input logic              flt_drv
);
    localparam int RW = $clog2(BLANK_CYC + 1);
    localparam logic [RW-1:0] RUN_MAX = RW'(BLANK_CYC);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)                 run_q <= '0;
        else if (!trip)          run_q <= '0;
        else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
    end

    // R1
    trip_blank_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(flt_drv) && !vcc_uv) |-> (run_q == RUN_MAX));

    // R1
    fault_all_off_chk: assert property (@(posedge clk) disable iff (rst)
        flt_drv |-> (hs_en == '0 && ls_en == '0));

    // R2
    fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (flt_drv && !vcc_uv && !(&lin_n)) |=> flt_drv);

    // R4
    supply_low_chk: assert property (@(posedge clk) disable iff (rst)
        vcc_uv |-> (flt_drv && ls_en == '0));

    // R5
    vbs_block_chk: assert property (@(posedge clk) disable iff (rst)
        (hs_en & vbs_uv) == '0);

    // R7
    transient_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (hs_en & (neg_tr | $past(neg_tr))) == '0);

    for (genvar p = 0; p < PHASES; p++) begin : g_rearm
        // R6
        rearm_wait_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(vbs_uv[p]) |-> !hs_en[p]);
    end

endmodule

bind bridge_guard bridge_guard_chk #(
    .PHASES    (PHASES),
    .BLANK_CYC (BLANK_CYC)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .lin_n   (lin_n),
    .trip    (trip),
    .vcc_uv  (vcc_uv),
    .vbs_uv  (vbs_uv),
    .neg_tr  (neg_tr),
    .hs_en   (hs_en),
    .ls_en   (ls_en),
    .flt_drv (flt_drv)
);

// File: tb/sim_bridge_guard.sv
`timescale 1ns/1ps
module sim_bridge_guard;
    localparam int NB = 4;
    localparam int NC = 10;
    localparam int NH = 8;

    logic clk = 1'b0;
    logic rst;
    logic [2:0] hin_n, lin_n, vbs_uv, neg_tr;
    logic trip, vcc_uv;
    logic [2:0] hs_en, ls_en;
    logic flt_drv, flt_n;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    logic [6:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    bridge_guard #(.PHASES(3), .BLANK_CYC(NB), .CLEAR_CYC(NC), .HOLD_CYC(NH)) u0 (
        .clk(clk), .rst(rst), .hin_n(hin_n), .lin_n(lin_n), .trip(trip),
        .vcc_uv(vcc_uv), .vbs_uv(vbs_uv), .neg_tr(neg_tr),
        .hs_en(hs_en), .ls_en(ls_en), .flt_drv(flt_drv), .flt_n(flt_n)
    );

    // Driver: one call = one cycle of inputs plus the outputs expected in it
    task automatic step(input logic r, input logic [2:0] h, input logic [2:0] l,
                        input logic t, input logic v, input logic [2:0] vb,
                        input logic [2:0] ng, input logic [2:0] e_hs,
                        input logic [2:0] e_ls, input logic e_drv, input string tag);
        @(posedge clk);
        #1;
        rst = r; hin_n = h; lin_n = l; trip = t; vcc_uv = v; vbs_uv = vb; neg_tr = ng;
        exp_q.push_back({e_hs, e_ls, e_drv});
        tag_q.push_back(tag);
    endtask

    task automatic steps(input int n, input logic [2:0] h, input logic [2:0] l,
                         input logic t, input logic v, input logic [2:0] vb,
                         input logic [2:0] ng, input logic [2:0] e_hs,
                         input logic [2:0] e_ls, input logic e_drv, input string tag);
        for (int k = 0; k < n; k++) step(1'b0, h, l, t, v, vb, ng, e_hs, e_ls, e_drv, tag);
    endtask

    // Monitor: pops one expectation per cycle, sampled at the falling edge
    initial begin
        logic [6:0] e;
        string tg;
        forever begin
            @(negedge clk);
            if (exp_q.size() != 0) begin
                e  = exp_q.pop_front();
                tg = tag_q.pop_front();
                total++;
                // R9: flt_n must always be the inverse of flt_drv
                if ({hs_en, ls_en, flt_drv} !== e || flt_n !== ~e[0]) begin
                    fails++;
                    $display("FAIL %s (R9 pin pair included): got hs=%b ls=%b drv=%b fn=%b, exp hs=%b ls=%b drv=%b fn=%b",
                             tg, hs_en, ls_en, flt_drv, flt_n, e[6:4], e[3:1], e[0], ~e[0]);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: got no end of stimulus, exp end within 20000 cycles");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; hin_n = 3'b111; lin_n = 3'b111; trip = 1'b0;
        vcc_uv = 1'b0; vbs_uv = 3'b000; neg_tr = 3'b000;

        // R8: reset state, then armed high sides
        step(1'b1, 3'b111, 3'b111, 0, 0, 3'b000, 3'b000, 3'b000, 3'b000, 0, "R8 in reset");
        step(1'b1, 3'b111, 3'b111, 0, 0, 3'b000, 3'b000, 3'b000, 3'b000, 0, "R8 in reset");
        steps(2, 3'b111, 3'b111, 0, 0, 3'b000, 3'b000, 3'b000, 3'b111, 0, "R8 after reset");

        // R6: turn-on edge on phase 0, then phases 1 and 2
        steps(1, 3'b110, 3'b111, 0, 0, 3'b000, 3'b000, 3'b000, 3'b111, 0, "R6 edge cycle p0");
        steps(1, 3'b110, 3'b111, 0, 0, 3'b000, 3'b000, 3'b001, 3'b111, 0, "R6 p0 enabled");
        steps(1, 3'b000, 3'b111, 0, 0, 3'b000, 3'b000, 3'b001, 3'b111, 0, "R6 edge cycle p1 p2");
        steps(1, 3'b000, 3'b111, 0, 0, 3'b000, 3'b000, 3'b111, 3'b111, 0, "R6 all enabled");

        // R5: floating undervoltage on phase 1 only
        steps(2, 3'b000, 3'b111, 0, 0, 3'b010, 3'b000, 3'b101, 3'b111, 0, "R5 p1 blocked");
        // R6: no fresh edge after recovery, stays off
        steps(3, 3'b000, 3'b111, 0, 0, 3'b000, 3'b000, 3'b101, 3'b111, 0, "R6 waits for edge");
        // R6: an edge during undervoltage is ignored
        steps(1, 3'b010, 3'b111, 0, 0, 3'b010, 3'b000, 3'b101, 3'b111, 0, "R5 p1 blocked");
        steps(1, 3'b000, 3'b111, 0, 0, 3'b010, 3'b000, 3'b101, 3'b111, 0, "R6 edge during uv");
        steps(2, 3'b000, 3'b111, 0, 0, 3'b000, 3'b000, 3'b101, 3'b111, 0, "R6 uv edge ignored");
        steps(1, 3'b010, 3'b111, 0, 0, 3'b000, 3'b000, 3'b101, 3'b111, 0, "R6 command off");
        steps(1, 3'b000, 3'b111, 0, 0, 3'b000, 3'b000, 3'b101, 3'b111, 0, "R6 edge cycle p1");
        steps(1, 3'b000, 3'b111, 0, 0, 3'b000, 3'b000, 3'b111, 3'b111, 0, "R6 p1 rearmed");

        // R7: transient on phase 2, hold NH cycles after the flag drops
        steps(2, 3'b000, 3'b111, 0, 0, 3'b000, 3'b100, 3'b011, 3'b111, 0, "R7 flag high");
        steps(NH, 3'b000, 3'b111, 0, 0, 3'b000, 3'b000, 3'b011, 3'b111, 0, "R7 hold window");
        steps(1, 3'b000, 3'b111, 0, 0, 3'b000, 3'b000, 3'b111, 3'b111, 0, "R7 hold over");

        // R1: trip shorter than the blanking run has no effect
        steps(NB-1, 3'b000, 3'b111, 1, 0, 3'b000, 3'b000, 3'b111, 3'b111, 0, "R1 short trip");
        steps(1, 3'b000, 3'b111, 0, 0, 3'b000, 3'b000, 3'b111, 3'b111, 0, "R1 short trip ignored");
        // R1: full blanking run then shutdown
        steps(NB, 3'b000, 3'b111, 1, 0, 3'b000, 3'b000, 3'b111, 3'b111, 0, "R1 blanking");
        steps(1, 3'b000, 3'b111, 1, 0, 3'b000, 3'b000, 3'b000, 3'b000, 1, "R1 shutdown");
        // R3: live trip blocks clearing even with idle low sides
        steps(NC+2, 3'b000, 3'b111, 1, 0, 3'b000, 3'b000, 3'b000, 3'b000, 1, "R3 trip blocks clear");
        // R2: latched with low-side commands active
        steps(15, 3'b000, 3'b000, 0, 0, 3'b000, 3'b000, 3'b000, 3'b000, 1, "R2 latched");
        // R3: partial run, interrupted, then full run
        steps(5, 3'b000, 3'b111, 0, 0, 3'b000, 3'b000, 3'b000, 3'b000, 1, "R3 partial run");
        steps(1, 3'b000, 3'b011, 0, 0, 3'b000, 3'b000, 3'b000, 3'b000, 1, "R3 run broken");
        steps(NC, 3'b000, 3'b111, 0, 0, 3'b000, 3'b000, 3'b000, 3'b000, 1, "R3 full run");
        steps(2, 3'b000, 3'b111, 0, 0, 3'b000, 3'b000, 3'b111, 3'b111, 0, "R3 released");

        // R4: logic supply undervoltage, not latched
        steps(2, 3'b000, 3'b000, 0, 1, 3'b000, 3'b000, 3'b000, 3'b000, 1, "R4 supply low");
        steps(2, 3'b000, 3'b000, 0, 0, 3'b000, 3'b000, 3'b111, 3'b111, 0, "R4 recovered");

        @(posedge clk);
        @(posedge clk);
        @(posedge clk);
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule